// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block sequences master-mode transactions on a byte-level bus engine. The engine accepts four operations: start-with-address, send byte, receive byte and stop. It answers in the same cycle with an acknowledge and, for a receive, the byte read. The host writes a 16-bit control word and sets a slave address and a transfer count. It moves payload through a four-byte transmit buffer and a four-byte receive buffer. The sequencer issues the start, then runs at most one byte operation per clock while the bus is held. It ends the transfer by count or on request, and it reports acknowledge failures.

There are two modes. In count mode a working counter, loaded from the programmed count at start, is decremented per byte. At zero the sequencer either issues stop, if stop is pending, or raises access-ready and drops the master bit. In loop mode the count is ignored. Transmit drains whatever is buffered, receive keeps the buffer topped up, and only a stop request ends the transfer.

Top module: `i2c_xfer_seq`

## Requirements
- R1: A control write stores only the bits of mask 0xCF87 and `ctl_q` returns them. Bit 15 is enable, 10 master, 9 transmit, 8 wide addressing, 2 loop mode, 1 stop request and 0 start request. After reset every output register, flag and buffer is zero or empty.
- R2: With LEGACY_RESET set (the default), a control write with bit 15 clear issues no bus operation. It returns control, count, busy state, both flags and both buffers to their reset values.
- R3: A control write with bits 15 and 10 set, bit 8 clear and bit 0 set issues a start in that cycle. `eng_op` codes are 0 start, 1 send, 2 receive and 3 stop, and `eng_req` qualifies them. The start carries `eng_addr` = `slave_addr` and `eng_read` = inverse of bit 9. The start bit is then cleared and both buffers are emptied. If the address is acknowledged, `bus_busy` rises and `cur_count` loads `xfer_count`.
- R4: An unacknowledged start sets `flag_nack`, clears the stop bit and leaves `bus_busy` low.
- R5: In count mode while transmitting, buffered bytes go out oldest first, one per cycle, and `cur_count` drops by one per byte. When `cur_count` is zero and stop is not pending, `flag_ardy` is set and the master bit is cleared, after which no operation is issued.
- R6: `tx_room` is high exactly when the bus is held, enable, master and transmit are set, `flag_nack` is low, loop mode is set or `cur_count` is non-zero, and the transmit buffer holds fewer than 4 bytes.
- R7: In count mode while receiving, a receive is issued per cycle while `cur_count` is non-zero and fewer than 4 bytes are held. `rx_avail` shows a non-empty buffer, `rx_byte` its oldest byte, and `rx_pop` removes it.
- R8: In count mode at zero count with stop pending, a stop is issued. Then `bus_busy` falls, the stop bit clears, `cur_count` reloads from `xfer_count` and the transmit buffer is emptied.
- R9: In loop mode `cur_count` is left unchanged. Transmit sends while bytes are buffered, receive fills to 4 bytes, and a pending stop bit issues a stop with the effects of R8.
- R10: An unacknowledged sent byte sets `flag_nack` and clears the stop bit. While `flag_nack` is set, no operation is issued except on a control write.
- R11: `stat_clr` bit 0 clears `flag_nack` and bit 1 clears `flag_ardy`. A flag-setting event in the same cycle wins over the clear.
- R12: A `tx_push` while the transmit buffer already holds 4 bytes is dropped and changes no buffered byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 16 | Control write value |
| xfer_count | input | CNT_W | Programmed transfer count |
| slave_addr | input | ADDR_W | Target address for start |
| tx_push | input | 1 | Push one byte into the transmit buffer |
| tx_byte | input | 8 | Byte to push |
| rx_pop | input | 1 | Remove the oldest received byte |
| stat_clr | input | 2 | Clear strobes: bit 0 NACK, bit 1 access-ready |
| eng_ack | input | 1 | Engine acknowledge for start or send |
| eng_rdata | input | 8 | Engine byte for a receive |
| ctl_q | output | 16 | Current control word |
| cur_count | output | CNT_W | Working count |
| bus_busy | output | 1 | Bus held by this master |
| flag_nack | output | 1 | Not-acknowledged flag |
| flag_ardy | output | 1 | Access-ready flag |
| tx_room | output | 1 | Transmit-ready level |
| rx_avail | output | 1 | Receive buffer non-empty |
| rx_byte | output | 8 | Oldest received byte |
| eng_req | output | 1 | Engine operation valid this cycle |
| eng_op | output | 2 | Engine operation code |
| eng_addr | output | ADDR_W | Address for start |
| eng_read | output | 1 | Direction for start, 1 = read |
| eng_wdata | output | 8 | Byte for send |

## Verification
The hardest state to reach is a full transmit buffer. While a transfer runs, each byte is sent in the cycle after its push, so the buffer never fills. The stimulus starts a transmit with a zero count so the sequencer parks at access-ready, pushes five bytes, then switches to loop mode to watch exactly four drain. A NACK on a middle byte of a count-mode transmit with stop pending is also set up. The acknowledge level is dropped between two pushes, and the halt, the cleared stop bit and the resumption after the flag is cleared are all followed.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    // Control word layout: kept bits and field positions
    localparam logic [15:0] CTL_KEEP = 16'hCF87;
    localparam int B_ENABLE   = 15;
    localparam int B_MASTER   = 10;
    localparam int B_XMIT     = 9;
    localparam int B_WIDEADDR = 8;
    localparam int B_LOOP     = 2;
    localparam int B_HALT     = 1;
    localparam int B_GO       = 0;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_WRITE,
        ACT_WIPE,
        ACT_START,
        ACT_SEND,
        ACT_RECV,
        ACT_STOP,
        ACT_ARDY
    } act_e;

    typedef struct packed {
        logic enable;
        logic master;
        logic xmit;
        logic loop;
        logic halt;
    } run_bits_t;

    function automatic logic start_ok(logic [15:0] c);
        return c[B_ENABLE] && c[B_MASTER] && !c[B_WIDEADDR] && c[B_GO];
    endfunction

    function automatic bus_op_e op_of(act_e a);
        case (a)
            ACT_SEND: return OP_SEND;
            ACT_RECV: return OP_RECV;
            ACT_STOP: return OP_STOP;
            default:  return OP_START;
        endcase
    endfunction

    function automatic logic is_bus_act(act_e a);
        return (a == ACT_START) || (a == ACT_SEND) || (a == ACT_RECV) || (a == ACT_STOP);
    endfunction

endpackage

// File: rtl/i2cseq_bytebuf.sv
module i2cseq_bytebuf #(
    parameter int DEPTH = 4,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [7:0]    din,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [LW-1:0] level
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]    mem [DEPTH];
    logic          take;
    logic          give;
    logic [LW-1:0] wr_at;

    assign take  = push && (level < LW'(DEPTH));
    assign give  = pop && (level != '0);
    assign wr_at = level - LW'(give);
    assign head  = mem[0];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            level <= '0;
        end else begin
            if (give) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    mem[i] <= mem[i + 1];
                end
                mem[DEPTH - 1] <= 8'h00;
            end
            if (take) begin
                mem[IW'(wr_at)] <= din;
            end
            level <= level + LW'(take) - LW'(give);
        end
    end

    // R12: the buffer never holds more than DEPTH bytes
    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

endmodule

// File: rtl/i2cseq_step.sv
module i2cseq_step
    import i2cseq_pkg::*;
#(
    parameter bit LEGACY_RESET = 1'b1
) (
    input  logic      ctl_wr,
    input  logic      wr_enable,
    input  logic      wr_start,
    input  run_bits_t cur,
    input  logic      busy,
    input  logic      nack_flag,
    input  logic      cnt_zero,
    input  logic      tx_empty,
    input  logic      rx_full,
    output act_e      act
);
    logic running;
    assign running = busy && cur.enable && cur.master && !nack_flag;

    always_comb begin
        act = ACT_NONE;
        if (ctl_wr) begin
            if (!wr_enable)    act = LEGACY_RESET ? ACT_WIPE : ACT_WRITE;
            else if (wr_start) act = ACT_START;
            else               act = ACT_WRITE;
        end else if (running) begin
            if (cur.loop) begin
                if (cur.halt)                 act = ACT_STOP;
                else if (cur.xmit) begin
                    if (!tx_empty)            act = ACT_SEND;
                end else if (!rx_full)        act = ACT_RECV;
            end else if (cnt_zero) begin
                act = cur.halt ? ACT_STOP : ACT_ARDY;
            end else if (cur.xmit) begin
                if (!tx_empty)                act = ACT_SEND;
            end else if (!rx_full) begin
                act = ACT_RECV;
            end
        end
    end

endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
    import i2cseq_pkg::*;
#(
    parameter int DEPTH        = 4,
    parameter int CNT_W        = 16,
    parameter int ADDR_W       = 10,
    parameter bit LEGACY_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [15:0]       ctl_wdata,
    input  logic [CNT_W-1:0]  xfer_count,
    input  logic [ADDR_W-1:0] slave_addr,
    input  logic              tx_push,
    input  logic [7:0]        tx_byte,
    input  logic              rx_pop,
    input  logic [1:0]        stat_clr,
    input  logic              eng_ack,
    input  logic [7:0]        eng_rdata,
    output logic [15:0]       ctl_q,
    output logic [CNT_W-1:0]  cur_count,
    output logic              bus_busy,
    output logic              flag_nack,
    output logic              flag_ardy,
    output logic              tx_room,
    output logic              rx_avail,
    output logic [7:0]        rx_byte,
    output logic              eng_req,
    output logic [1:0]        eng_op,
    output logic [ADDR_W-1:0] eng_addr,
    output logic              eng_read,
    output logic [7:0]        eng_wdata
);
    localparam int LW = $clog2(DEPTH + 1);

    logic [15:0]      ctl_r;
    logic [15:0]      new_ctl;
    logic [CNT_W-1:0] wcnt_r;
    logic             busy_r, nack_r, ardy_r;
    logic [LW-1:0]    tx_lvl, rx_lvl;
    logic [7:0]       tx_head;
    run_bits_t        cur;
    act_e             act;
    logic             tx_flush, rx_flush, nack_evt;

    assign new_ctl = ctl_wdata & CTL_KEEP;
    assign cur     = '{enable: ctl_r[B_ENABLE], master: ctl_r[B_MASTER],
                       xmit: ctl_r[B_XMIT], loop: ctl_r[B_LOOP], halt: ctl_r[B_HALT]};

    i2cseq_step #(.LEGACY_RESET(LEGACY_RESET)) u_step (
        .ctl_wr    (ctl_wr),
        .wr_enable (new_ctl[B_ENABLE]),
        .wr_start  (start_ok(new_ctl)),
        .cur       (cur),
        .busy      (busy_r),
        .nack_flag (nack_r),
        .cnt_zero  (wcnt_r == '0),
        .tx_empty  (tx_lvl == '0),
        .rx_full   (rx_lvl == LW'(DEPTH)),
        .act       (act)
    );

    assign tx_flush = (act == ACT_START) || (act == ACT_STOP) || (act == ACT_WIPE);
    assign rx_flush = (act == ACT_START) || (act == ACT_WIPE);
    assign nack_evt = ((act == ACT_START) || (act == ACT_SEND)) && !eng_ack;

    i2cseq_bytebuf #(.DEPTH(DEPTH)) u_txbuf (
        .clk(clk), .rst(rst), .flush(tx_flush),
        .push(tx_push), .din(tx_byte), .pop(act == ACT_SEND),
        .head(tx_head), .level(tx_lvl)
    );

    i2cseq_bytebuf #(.DEPTH(DEPTH)) u_rxbuf (
        .clk(clk), .rst(rst), .flush(rx_flush),
        .push(act == ACT_RECV), .din(eng_rdata), .pop(rx_pop),
        .head(rx_byte), .level(rx_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_r  <= '0;
            wcnt_r <= '0;
            busy_r <= 1'b0;
            nack_r <= 1'b0;
            ardy_r <= 1'b0;
        end else begin
            case (act)
                ACT_WIPE: begin
                    ctl_r  <= '0;
                    wcnt_r <= '0;
                    busy_r <= 1'b0;
                end
                ACT_WRITE: ctl_r <= new_ctl;
                ACT_START: begin
                    ctl_r       <= new_ctl;
                    ctl_r[B_GO] <= 1'b0;
                    busy_r      <= eng_ack;
                    if (eng_ack) wcnt_r <= xfer_count;
                    else         ctl_r[B_HALT] <= 1'b0;
                end
                ACT_SEND, ACT_RECV: begin
                    if (!cur.loop) wcnt_r <= wcnt_r - CNT_W'(1);
                    if (act == ACT_SEND && !eng_ack) ctl_r[B_HALT] <= 1'b0;
                end
                ACT_STOP: begin
                    busy_r        <= 1'b0;
                    ctl_r[B_HALT] <= 1'b0;
                    wcnt_r        <= xfer_count;
                end
                ACT_ARDY: ctl_r[B_MASTER] <= 1'b0;
                default: ;
            endcase

            if (act == ACT_WIPE)  nack_r <= 1'b0;
            else if (nack_evt)    nack_r <= 1'b1;
            else if (stat_clr[0]) nack_r <= 1'b0;

            if (act == ACT_WIPE)       ardy_r <= 1'b0;
            else if (act == ACT_ARDY)  ardy_r <= 1'b1;
            else if (stat_clr[1])      ardy_r <= 1'b0;
        end
    end

    assign ctl_q     = ctl_r;
    assign cur_count = wcnt_r;
    assign bus_busy  = busy_r;
    assign flag_nack = nack_r;
    assign flag_ardy = ardy_r;
    assign rx_avail  = (rx_lvl != '0);
    assign tx_room   = busy_r && cur.enable && cur.master && cur.xmit && !nack_r
                       && (cur.loop || wcnt_r != '0) && (tx_lvl < LW'(DEPTH));
    assign eng_req   = is_bus_act(act);
    assign eng_op    = op_of(act);
    assign eng_addr  = slave_addr;
    assign eng_read  = ~new_ctl[B_XMIT];
    assign eng_wdata = tx_head;

    // R3: an acknowledged start leaves the bus held, start cleared, count loaded
    assert_start_load_R3: assert property (@(posedge clk) disable iff (rst)
        (eng_req && eng_op == OP_START && eng_ack) |=>
            (bus_busy && !ctl_q[B_GO] && !rx_avail && cur_count == $past(xfer_count)));

    // R4: an unacknowledged start raises NACK and keeps the bus free
    assert_addr_nack_R4: assert property (@(posedge clk) disable iff (rst)
        (eng_req && eng_op == OP_START && !eng_ack) |=>
            (flag_nack && !ctl_q[B_HALT] && !bus_busy));

    // R5: count mode byte operations decrement the working count by one
    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        (eng_req && (eng_op == OP_SEND || eng_op == OP_RECV) && !ctl_q[B_LOOP]) |=>
            (cur_count == CNT_W'($past(cur_count) - CNT_W'(1))));

    // R5: access-ready rises together with the master bit dropping
    assert_ardy_master_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_ardy) |-> !ctl_q[B_MASTER]);

    // R7: no receive while the receive buffer is full
    assert_rx_cap_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_lvl == LW'(DEPTH)) |-> !(eng_req && eng_op == OP_RECV));

    // R8: a stop releases the bus, clears stop and reloads the count
    assert_stop_release_R8: assert property (@(posedge clk) disable iff (rst)
        (eng_req && eng_op == OP_STOP) |=>
            (!bus_busy && !ctl_q[B_HALT] && cur_count == $past(xfer_count)));

    // R9: loop mode byte operations leave the count alone
    assert_loop_count_R9: assert property (@(posedge clk) disable iff (rst)
        (eng_req && (eng_op == OP_SEND || eng_op == OP_RECV) && ctl_q[B_LOOP]) |=>
            $stable(cur_count));

    // R10: nothing runs while NACK is pending unless the host writes control
    assert_nack_halt_R10: assert property (@(posedge clk) disable iff (rst)
        (flag_nack && !ctl_wr) |-> !eng_req);

endmodule

// File: tb/i2c_xfer_seq_bench.sv
module i2c_xfer_seq_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] xfer_count = '0;
    logic [9:0]  slave_addr = '0;
    logic        tx_push = 1'b0;
    logic [7:0]  tx_byte = '0;
    logic        rx_pop = 1'b0;
    logic [1:0]  stat_clr = '0;
    logic        eng_ack = 1'b1;
    logic [7:0]  eng_rdata = 8'h40;

    logic [15:0] ctl_q;
    logic [15:0] cur_count;
    logic        bus_busy, flag_nack, flag_ardy, tx_room, rx_avail;
    logic [7:0]  rx_byte;
    logic        eng_req;
    logic [1:0]  eng_op;
    logic [9:0]  eng_addr;
    logic        eng_read;
    logic [7:0]  eng_wdata;

    i2c_xfer_seq u_i2c_xfer_seq (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .xfer_count(xfer_count), .slave_addr(slave_addr),
        .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop), .stat_clr(stat_clr),
        .eng_ack(eng_ack), .eng_rdata(eng_rdata),
        .ctl_q(ctl_q), .cur_count(cur_count), .bus_busy(bus_busy),
        .flag_nack(flag_nack), .flag_ardy(flag_ardy), .tx_room(tx_room),
        .rx_avail(rx_avail), .rx_byte(rx_byte), .eng_req(eng_req), .eng_op(eng_op),
        .eng_addr(eng_addr), .eng_read(eng_read), .eng_wdata(eng_wdata)
    );

    int    n_run = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    string tag   = "R1";

    // Behavioural reference state
    logic [15:0]  m_ctl  = '0;
    bit           m_busy = 0, m_nack = 0, m_ardy = 0;
    int           m_cnt  = 0;
    int           recv_n = 0;
    byte unsigned txq[$];
    byte unsigned rxq[$];

    task automatic chk(string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        int          a;
        int          e_op;
        bit          e_req, room, push_ok, pop_ok;
        logic [15:0] nc;
        #1;
        nc = ctl_wdata & 16'hCF87;
        a  = 0;
        if (ctl_wr) begin
            if (!nc[15])                         a = 2;
            else if (nc[10] && !nc[8] && nc[0])  a = 3;
            else                                 a = 1;
        end else if (m_busy && m_ctl[15] && m_ctl[10] && !m_nack) begin
            if (m_ctl[2]) begin
                if (m_ctl[1])                       a = 6;
                else if (m_ctl[9]) begin
                    if (txq.size() > 0)             a = 4;
                end else if (rxq.size() < 4)        a = 5;
            end else if (m_cnt == 0) begin
                a = m_ctl[1] ? 6 : 7;
            end else if (m_ctl[9]) begin
                if (txq.size() > 0)                 a = 4;
            end else if (rxq.size() < 4)            a = 5;
        end
        e_req = (a >= 3 && a <= 6);
        e_op  = (a == 4) ? 1 : (a == 5) ? 2 : (a == 6) ? 3 : 0;
        room  = m_busy && m_ctl[15] && m_ctl[10] && m_ctl[9] && !m_nack
                && (m_ctl[2] || m_cnt != 0) && txq.size() < 4;

        chk("ctl_q", int'(ctl_q), int'(m_ctl));
        chk("cur_count", int'(cur_count), m_cnt);
        chk("bus_busy", int'(bus_busy), int'(m_busy));
        chk("flag_nack", int'(flag_nack), int'(m_nack));
        chk("flag_ardy", int'(flag_ardy), int'(m_ardy));
        chk("tx_room", int'(tx_room), int'(room));
        chk("rx_avail", int'(rx_avail), int'(rxq.size() != 0));
        if (rxq.size() != 0) chk("rx_byte", int'(rx_byte), int'(rxq[0]));
        chk("eng_req", int'(eng_req), int'(e_req));
        if (e_req) begin
            chk("eng_op", int'(eng_op), e_op);
            if (a == 4) chk("eng_wdata", int'(eng_wdata), int'(txq[0]));
            if (a == 3) begin
                chk("eng_addr", int'(eng_addr), int'(slave_addr));
                chk("eng_read", int'(eng_read), int'(!nc[9]));
            end
        end

        push_ok = tx_push && txq.size() < 4;
        pop_ok  = rx_pop && rxq.size() > 0;
        case (a)
            1: m_ctl = nc;
            2: begin
                m_ctl = '0; m_busy = 0; m_cnt = 0; m_nack = 0; m_ardy = 0;
                txq.delete(); rxq.delete(); push_ok = 0; pop_ok = 0;
            end
            3: begin
                m_ctl = nc; m_ctl[0] = 1'b0;
                txq.delete(); rxq.delete(); push_ok = 0; pop_ok = 0;
                if (eng_ack) begin m_busy = 1; m_cnt = int'(xfer_count); end
                else begin m_busy = 0; m_ctl[1] = 1'b0; end
            end
            4: begin
                void'(txq.pop_front());
                if (!m_ctl[2]) m_cnt--;
                if (!eng_ack) m_ctl[1] = 1'b0;
            end
            5: if (!m_ctl[2]) m_cnt--;
            6: begin
                m_busy = 0; m_ctl[1] = 1'b0; m_cnt = int'(xfer_count);
                txq.delete(); push_ok = 0;
            end
            7: m_ctl[10] = 1'b0;
            default: ;
        endcase
        if (a != 2) begin
            if (stat_clr[0]) m_nack = 0;
            if ((a == 3 || a == 4) && !eng_ack) m_nack = 1;
            if (stat_clr[1]) m_ardy = 0;
            if (a == 7) m_ardy = 1;
        end
        if (pop_ok) void'(rxq.pop_front());
        if (a == 5) begin rxq.push_back(eng_rdata); recv_n++; end
        if (push_ok) txq.push_back(tx_byte);

        @(posedge clk);
        @(negedge clk);
        ctl_wr = 1'b0; tx_push = 1'b0; rx_pop = 1'b0; stat_clr = '0;
        eng_rdata = 8'(8'h40 + recv_n);
    endtask

    task automatic wr_ctl(logic [15:0] v);
        ctl_wr = 1'b1; ctl_wdata = v; tick();
    endtask
    task automatic push(logic [7:0] b);
        tx_push = 1'b1; tx_byte = b; tick();
    endtask
    task automatic pop();
        rx_pop = 1'b1; tick();
    endtask
    task automatic clr(logic [1:0] v);
        stat_clr = v; tick();
    endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_run++; n_bad++;
            $display("FAIL watchdog R1: actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 1'b0;

        tag = "R1"; idle(2);
        wr_ctl(16'hFFFF); idle(1);              // wide addressing blocks start
        tag = "R2"; wr_ctl(16'h0401); idle(1);  // enable clear: wipe, no op

        // Count-mode transmit
        xfer_count = 16'd3; slave_addr = 10'h055; eng_ack = 1'b1;
        tag = "R3"; wr_ctl(16'h8601);
        tag = "R6"; idle(1);
        tag = "R5"; push(8'hAA); push(8'hBB); push(8'hCC); idle(3);
        tag = "R11"; clr(2'b10);
        tag = "R8"; wr_ctl(16'h8602); idle(2);

        // Full transmit buffer, then loop-mode drain
        tag = "R12"; xfer_count = 16'd0; wr_ctl(16'h8601); idle(1);
        for (int i = 0; i < 5; i++) push(8'(8'h11 + i));
        tag = "R9"; wr_ctl(16'h8604); idle(6);
        wr_ctl(16'h8606); idle(1);
        tag = "R11"; clr(2'b10);

        // Count-mode receive
        tag = "R7"; xfer_count = 16'd6; slave_addr = 10'h3A1; wr_ctl(16'h8401); idle(5);
        pop(); pop(); idle(3);
        for (int i = 0; i < 4; i++) pop();
        tag = "R8"; wr_ctl(16'h8402); idle(1);
        xfer_count = 16'd2; wr_ctl(16'h8403); idle(4); pop(); pop();

        // Loop-mode receive
        tag = "R9"; xfer_count = 16'd1; wr_ctl(16'h8405); idle(5);
        pop(); idle(2); wr_ctl(16'h8406); idle(1);
        for (int i = 0; i < 4; i++) pop();

        // Address NACK
        tag = "R4"; eng_ack = 1'b0; wr_ctl(16'h8603); idle(2);
        tag = "R11"; clr(2'b01); idle(1); eng_ack = 1'b1;

        // Data NACK mid transfer with stop pending
        tag = "R10"; xfer_count = 16'd4; wr_ctl(16'h8603);
        push(8'h01); idle(1);
        eng_ack = 1'b0; push(8'h02); idle(1);
        push(8'h03); idle(2);
        eng_ack = 1'b1; clr(2'b01); idle(1);
        push(8'h04); idle(2);
        tag = "R8"; wr_ctl(16'h8602); idle(1);

        // Set wins over clear, then wipe clears the flag
        tag = "R11"; eng_ack = 1'b0; stat_clr = 2'b01; wr_ctl(16'h8601); idle(1);
        eng_ack = 1'b1;
        tag = "R2"; wr_ctl(16'h0000); idle(2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule